// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-visible register set of one DMA channel. A processor reaches four 32-bit words through a single-cycle word bus port: a control/status word, a transfer address, a byte count and an upper-address base. The control word is not stored as written. The block rewrites each control write before storing it. Certain bits keep their old value, the top nibble always carries a fixed version code, a drain request clears itself, and a write of all zeros turns into a drain request.

On the peripheral side, the block turns the peripheral's interrupt level into a pending bit. It gates that bit with an enable bit to drive the interrupt output. A control write with the reset bit set produces a one-cycle reset pulse for the peripheral. A small state machine follows the DMA-enable bit and drives a start level to the peripheral. The start state machine has two states, `ST_STOPPED` and `ST_RUNNING`. It takes the transition `ST_STOPPED -> ST_RUNNING` when a control write sets bit 9. It takes the transition `ST_RUNNING -> ST_STOPPED` when a control write clears bit 9. In every other case it holds its state. Each completed peripheral transfer advances the address register by that transfer's byte count.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control word reads 0xA0000000, the address, count and base words read 0, and `irq_out`, `per_start` and `per_reset_pulse` are low.
- R2: The word index is bus address bits [3:2] (0 control, 1 address, 2 count, 3 base). Higher address bits are ignored, so aliased addresses reach the same word.
- R3: `irq_out` is high exactly while control bit 0 (pending) and bit 4 (interrupt enable) are both set. It follows a write of bit 4 in the cycle after that write.
- R4: Control bit 0 takes the level of `per_irq_in` sampled at each clock edge. A bus write cannot change bit 0.
- R5: Control bits under mask 0xFE000007 keep their previous value on a control write. Bits [31:28] always read 0xA. All other bits take the rewritten write data.
- R6: A control write with bit 7 set makes `per_reset_pulse` high for exactly the one following cycle.
- R7: A control write with bit 6 set and bit 7 clear stores bit 6 as 0.
- R8: A control write of exactly 0x00000000 stores bit 6 as 1.
- R9: `per_start` goes high after a control write that sets bit 9 while the state machine is in `ST_STOPPED`. It goes low after a control write that clears bit 9 while it is in `ST_RUNNING`. It holds in every other case.
- R10: Any bus write to the address word sets control bit 26 (address loaded). This bit stays set until reset.
- R11: When `per_xfer_valid` is high, the address word increases by `per_xfer_bytes`, modulo 2^32.
- R12: If a bus write to the address word and a peripheral transfer fall in the same cycle, the written value is stored and the increment is dropped.
- R13: Reads return the addressed word combinationally and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| per_irq_in | input | 1 | Peripheral interrupt level |
| per_xfer_valid | input | 1 | A peripheral transfer completed this cycle |
| per_xfer_bytes | input | CNT_W | Byte count of that transfer |
| irq_out | output | 1 | Gated interrupt to the processor |
| per_reset_pulse | output | 1 | One-cycle reset to the peripheral |
| per_start | output | 1 | DMA start level to the peripheral |

## Verification
The assertions assume a few things about the inputs. `per_irq_in` is a level synchronous to `clk`. `per_xfer_bytes` matters only while `per_xfer_valid` is high. Every bus access is a whole word with `bus_sel` and `bus_wr` held stable for the cycle. The bench drives every input one step after a rising edge and holds `bus_sel` low during reset. This keeps every `$past` term of the checker within the cycles since reset. Transfers, aliased addresses and a write/increment collision are all placed deliberately, so that each corner case of the control-word rewrite and the address arbitration occurs at a known cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int WORD_W = 32;

    localparam int BIT_PEND   = 0;
    localparam int BIT_IEN    = 4;
    localparam int BIT_DRAIN  = 6;
    localparam int BIT_RST    = 7;
    localparam int BIT_TOMEM  = 8;
    localparam int BIT_RUN    = 9;
    localparam int BIT_LOADED = 26;

    localparam logic [WORD_W-1:0] KEEP_MASK = 32'hFE00_0007;
    localparam logic [3:0]        VER_CODE  = 4'hA;
    localparam logic [WORD_W-1:0] CSR_RESET = {VER_CODE, 28'h0};

    typedef enum logic [1:0] {
        IDX_CTRL  = 2'd0,
        IDX_ADDR  = 2'd1,
        IDX_COUNT = 2'd2,
        IDX_BASE  = 2'd3
    } word_idx_t;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } start_state_t;

endpackage

// File: rtl/dma_csr_unit.sv
module dma_csr_unit
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              loaded_set,
    input  logic              irq_level,
    output logic [WORD_W-1:0] csr_q,
    output logic              reset_pulse_q
);

    logic [WORD_W-1:0] rewritten;
    logic [WORD_W-1:0] csr_d;
    logic              pulse_d;

    // Rewrite of the incoming control value
    always_comb begin
        rewritten = wdata;
        pulse_d   = 1'b0;
        if (wdata[BIT_RST]) begin
            pulse_d = ctrl_we;
        end else if (wdata[BIT_DRAIN]) begin
            rewritten[BIT_DRAIN] = 1'b0;
        end else if (wdata == '0) begin
            rewritten[BIT_DRAIN] = 1'b1;
        end
    end

    // Next control word: keep-mask merge, version stamp, status inputs
    always_comb begin
        csr_d           = csr_q;
        csr_d[BIT_PEND] = irq_level;
        if (ctrl_we) begin
            csr_d = (csr_d & KEEP_MASK) | (rewritten & ~KEEP_MASK);
        end
        if (loaded_set) begin
            csr_d[BIT_LOADED] = 1'b1;
        end
        csr_d[WORD_W-1 -: 4] = VER_CODE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q         <= CSR_RESET;
            reset_pulse_q <= 1'b0;
        end else begin
            csr_q         <= csr_d;
            reset_pulse_q <= pulse_d;
        end
    end

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              xfer_valid,
    input  logic [CNT_W-1:0]  xfer_bytes,
    output logic [WORD_W-1:0] addr_q
);

    localparam int PAD_W = WORD_W - CNT_W;

    logic [WORD_W-1:0] step;
    logic [WORD_W-1:0] addr_d;

    generate
        if (PAD_W > 0) begin : g_pad
            assign step = {{PAD_W{1'b0}}, xfer_bytes};
        end else begin : g_trunc
            assign step = xfer_bytes[WORD_W-1:0];
        end
    endgenerate

    // Bus write has priority over the peripheral increment
    always_comb begin
        addr_d = addr_q;
        if (addr_we) begin
            addr_d = wdata;
        end else if (xfer_valid) begin
            addr_d = addr_q + step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/dma_start_fsm.sv
module dma_start_fsm
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic run_bit,
    output logic start_level
);

    start_state_t state_q;
    start_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (ctrl_we && run_bit)  state_d = ST_RUNNING;
            ST_RUNNING: if (ctrl_we && !run_bit) state_d = ST_STOPPED;
            default:    state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUNNING: start_level = 1'b1;
            default:    start_level = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              per_irq_in,
    input  logic              per_xfer_valid,
    input  logic [CNT_W-1:0]  per_xfer_bytes,
    output logic              irq_out,
    output logic              per_reset_pulse,
    output logic              per_start
);

    word_idx_t         idx;
    logic              wr_en;
    logic              ctrl_we;
    logic              addr_we;
    logic [WORD_W-1:0] csr_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] count_q;
    logic [WORD_W-1:0] base_q;

    assign idx     = word_idx_t'(bus_addr[3:2]);
    assign wr_en   = bus_sel && bus_wr;
    assign ctrl_we = wr_en && (idx == IDX_CTRL);
    assign addr_we = wr_en && (idx == IDX_ADDR);

    dma_csr_unit u_csr (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_we       (ctrl_we),
        .wdata         (bus_wdata),
        .loaded_set    (addr_we),
        .irq_level     (per_irq_in),
        .csr_q         (csr_q),
        .reset_pulse_q (per_reset_pulse)
    );

    dma_addr_unit #(.CNT_W(CNT_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (addr_we),
        .wdata      (bus_wdata),
        .xfer_valid (per_xfer_valid),
        .xfer_bytes (per_xfer_bytes),
        .addr_q     (addr_q)
    );

    dma_start_fsm u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .run_bit     (bus_wdata[BIT_RUN]),
        .start_level (per_start)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            base_q  <= '0;
        end else if (wr_en) begin
            if (idx == IDX_COUNT) count_q <= bus_wdata;
            if (idx == IDX_BASE)  base_q  <= bus_wdata;
        end
    end

    always_comb begin
        unique case (idx)
            IDX_CTRL:  bus_rdata = csr_q;
            IDX_ADDR:  bus_rdata = addr_q;
            IDX_COUNT: bus_rdata = count_q;
            default:   bus_rdata = base_q;
        endcase
    end

    assign irq_out = csr_q[BIT_PEND] && csr_q[BIT_IEN];

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              per_irq_in,
    input logic              per_xfer_valid,
    input logic              irq_out,
    input logic              per_reset_pulse,
    input logic              per_start,
    input logic [31:0]       csr_q,
    input logic [31:0]       addr_q
);

    logic ctrl_wr;
    logic addr_wr;
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr[3:2] == 2'd0);
    assign addr_wr = bus_sel && bus_wr && (bus_addr[3:2] == 2'd1);

    // R3 / R4: an asserted interrupt needs the peripheral level one edge earlier
    a_r3_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(per_irq_in));

    // R6: reset pulse only follows a control write carrying bit 7
    a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        per_reset_pulse |-> $past(ctrl_wr && bus_wdata[7]));

    // R9: start edges follow control writes of bit 9
    a_r9_start_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_start) |-> $past(ctrl_wr && bus_wdata[9]));

    a_r9_start_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(per_start) |-> $past(ctrl_wr && !bus_wdata[9]));

    // R5: version nibble never departs from 0xA
    a_r5_version: assert property (@(posedge clk) disable iff (!rst_n)
        csr_q[31:28] == 4'hA);

    // R10: address write leaves the loaded flag set
    a_r10_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> csr_q[26]);

    // R11 / R12: address word moves only on a write or a transfer
    a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_wr && !per_xfer_valid) |=> $stable(addr_q));

    // R12: a write wins over the increment
    a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (addr_q == $past(bus_wdata)));

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_sel         (bus_sel),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .per_irq_in      (per_irq_in),
    .per_xfer_valid  (per_xfer_valid),
    .irq_out         (irq_out),
    .per_reset_pulse (per_reset_pulse),
    .per_start       (per_start),
    .csr_q           (csr_q),
    .addr_q          (addr_q)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int CNT_W      = 16;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              per_irq_in = 1'b0;
    logic              per_xfer_valid = 1'b0;
    logic [CNT_W-1:0]  per_xfer_bytes = '0;
    logic              irq_out;
    logic              per_reset_pulse;
    logic              per_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // behavioural reference state
    logic [31:0] m_reg [4];
    bit          m_pulse;
    bit          m_start;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_irq_in(per_irq_in), .per_xfer_valid(per_xfer_valid),
        .per_xfer_bytes(per_xfer_bytes), .irq_out(irq_out),
        .per_reset_pulse(per_reset_pulse), .per_start(per_start)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // reference model: updated on each rising edge from inputs held stable since the last one
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg[0] = 32'hA000_0000;
            m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
            m_pulse  = 0;
            m_start  = 0;
        end else begin
            logic [31:0] nc;
            logic [31:0] v;
            int          wi;
            bit          we;
            nc    = m_reg[0];
            nc[0] = per_irq_in;
            m_pulse = 0;
            we = bus_sel && bus_wr;
            wi = int'(bus_addr) % 16 / 4;
            if (we && wi == 0) begin
                v = bus_wdata;
                if (v[7]) m_pulse = 1;
                else if (v[6]) v[6] = 0;
                else if (v == 0) v = 32'h40;
                nc = (nc & 32'hFE00_0007) | (v & 32'h01FF_FFF8);
                nc[31:28] = 4'hA;
                m_start = v[9];
            end
            if (we && wi == 1) begin
                m_reg[1] = bus_wdata;
                nc[26]   = 1;
            end else if (per_xfer_valid) begin
                m_reg[1] = m_reg[1] + 32'(per_xfer_bytes);
            end
            if (we && wi == 2) m_reg[2] = bus_wdata;
            if (we && wi == 3) m_reg[3] = bus_wdata;
            m_reg[0] = nc;
        end
    end

    // per-cycle comparison of the peripheral-side outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 irq_out", {31'b0, irq_out}, {31'b0, m_reg[0][0] & m_reg[0][4]});
            chk("R6 per_reset_pulse", {31'b0, per_reset_pulse}, {31'b0, m_pulse});
            chk("R9 per_start", {31'b0, per_start}, {31'b0, m_start});
        end
    end

    task automatic idle_cycle();
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; per_xfer_valid = 0;
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; per_xfer_valid = 0;
    endtask

    task automatic bus_read(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        bus_read("R1 ctrl", 8'h00, 32'hA000_0000);
        bus_read("R1 addr", 8'h04, 32'h0);
        bus_read("R1 count", 8'h08, 32'h0);
        bus_read("R1 base", 8'h0C, 32'h0);
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
        chk("R1 per_start", {31'b0, per_start}, 32'h0);
        // R2 aliasing through upper address bits
        bus_write(8'h3C, 32'h1234_5678);
        bus_read("R2 base via 0x0C", 8'h0C, 32'h1234_5678);
        bus_write(8'hA8, 32'hCAFE_0001);
        bus_read("R2 count via 0x08", 8'h08, 32'hCAFE_0001);
        // R13 reads have no side effects
        bus_read("R13 count repeat", 8'h08, 32'hCAFE_0001);
        bus_read("R13 ctrl unchanged", 8'h00, 32'hA000_0000);
        // R4 pending follows peripheral level, R3 gating
        @(posedge clk); #1 per_irq_in = 1;
        idle_cycle();
        bus_read("R4 pending set", 8'h00, 32'hA000_0001);
        chk("R3 gated off", {31'b0, irq_out}, 32'h0);
        bus_write(8'h00, 32'h0000_0010);
        @(negedge clk);
        chk("R3 irq on after enable", {31'b0, irq_out}, 32'h1);
        @(posedge clk); #1 per_irq_in = 0;
        idle_cycle();
        @(negedge clk);
        chk("R3 irq off after level low", {31'b0, irq_out}, 32'h0);
        bus_read("R4 pending cleared", 8'h00, 32'hA000_0010);
        // R8 zero write
        bus_write(8'h00, 32'h0);
        bus_read("R8 zero becomes drain", 8'h00, 32'hA000_0040);
        // R7 drain self-clear
        bus_write(8'h00, 32'h0000_0050);
        bus_read("R7 drain cleared", 8'h00, 32'hA000_0010);
        // R6 reset pulse
        bus_write(8'h00, 32'h0000_0080);
        bus_read("R6 stored reset bit", 8'h00, 32'hA000_0080);
        // R9 start state machine
        bus_write(8'h00, 32'h0000_0200);
        @(negedge clk);
        chk("R9 start high", {31'b0, per_start}, 32'h1);
        bus_write(8'h00, 32'h0000_0300);
        chk("R9 start holds", {31'b0, per_start}, 32'h1);
        bus_write(8'h00, 32'h0000_0010);
        @(negedge clk);
        chk("R9 start low", {31'b0, per_start}, 32'h0);
        // R5 keep-mask and version stamp
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read("R5 keep mask", 8'h00, 32'hA1FF_FFF8);
        bus_write(8'h00, 32'h5E00_0010);
        bus_read("R5 kept bits", 8'h00, 32'hA000_0010);
        // R10 loaded flag, R11 increment, R12 collision
        bus_write(8'h04, 32'h0000_1000);
        bus_read("R10 loaded set", 8'h00, 32'hA400_0010);
        @(posedge clk); #1 per_xfer_valid = 1; per_xfer_bytes = 16'd24;
        @(posedge clk); #1 per_xfer_bytes = 16'd8;
        idle_cycle();
        bus_read("R11 after two transfers", 8'h04, 32'h0000_1020);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'h0000_2000;
        per_xfer_valid = 1; per_xfer_bytes = 16'd100;
        idle_cycle();
        bus_read("R12 write wins", 8'h04, 32'h0000_2000);
        bus_write(8'h00, 32'h0000_0010);
        bus_read("R10 loaded persists", 8'h00, 32'hA400_0010);
        @(posedge clk); #1 per_xfer_valid = 1; per_xfer_bytes = 16'hFFFF;
        idle_cycle();
        bus_read("R11 wide step", 8'h04, 32'h0001_1FFF);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule